// File: doc/BRIEF.md
# Nonvolatile Memory Write Unlock Controller

This block sits between a small CPU register bus and the write port of a nonvolatile memory. Software loads a 22-bit table pointer and a data byte, sets a write-enable bit, and may then start a write. The start is taken only if the two bus accesses just before it were writes of two fixed key values, first 55h and then AAh, to a key address that stores nothing. This makes it very unlikely that a stray store starts a write.

A started write raises a one-cycle start strobe towards the memory and holds a CPU stall line until the memory reports completion. On completion the start bit clears itself and a sticky completion flag is set. A master-clear or watchdog reset that hits a running write leaves an error bit set across that reset, so software can tell that the location must be rewritten. Only a power-on reset clears that error bit.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: After power-on reset every register reads 0, and mem_start, cpu_stall and irq_flag are low. Address map: 0 control, 1 key, 2 pointer low, 3 pointer high, 4 pointer upper, 5 data latch, 6 completion flag. A read returns its data on bus_rdata one cycle after bus_re.
- R2: The key address reads as 0, and a write to it changes no readable register.
- R3: Control layout: bit 7 program/data target, bit 6 configuration space, bit 3 write error, bit 2 write enable, bit 1 start. A control write with bit 1 set starts a write only if write enable was already 1 and the two preceding bus accesses were key writes of 55h then AAh. mem_start is then high for exactly one cycle after that control write, and cpu_stall rises in the same cycle.
- R4: A key write of any other value, or any other bus access (read or write) between the key writes or between AAh and the control write, cancels the unlock and no write starts.
- R5: A start request made while write enable was 0 has no effect on the start bit.
- R6: cpu_stall and the start bit stay high until mem_done is seen; then both clear in the next cycle and irq_flag is set.
- R7: A control write with bit 1 clear does not clear the start bit while a write is running.
- R8: irq_flag (read at address 6, bit 0) stays set until software writes 0 to bit 0 there; writing 1 has no effect. If completion and that clearing write fall in the same cycle, the flag ends set.
- R9: A master-clear or watchdog reset during a running write sets the write-error bit, which survives that reset while all other state clears; without a running write it stays 0. Power-on reset clears it, and a control write with bit 3 clear clears it.
- R10: Pointer upper register keeps only bits 5:0; bits 7:6 read 0. mem_addr shows the 22-bit pointer, and mem_cfg is high when pointer bit 21 or control bit 6 is set.
- R11: Control bits 5, 4 and 0 read 0; mem_prog follows control bit 7 and mem_data follows the data latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mclr_rst | input | 1 | Master-clear reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mem_start | output | 1 | One-cycle write start strobe |
| cpu_stall | output | 1 | High while a write runs |
| mem_done | input | 1 | Memory reports write completion |
| mem_addr | output | 22 | Table pointer |
| mem_data | output | 8 | Data latch |
| mem_prog | output | 1 | Target select: 1 program memory, 0 data memory |
| mem_cfg | output | 1 | Configuration space access |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The completion report from the memory and a software write that clears the completion flag can land on the same clock edge, and the two pull the flag in opposite directions. The bench starts a write, then in one cycle drives mem_done high together with a write of 0 to the flag register, and judges by reading the flag back and watching irq_flag: it must be set. A second pairing, a warm reset arriving while the stall is high, is judged by reading the control register after the reset and expecting only the error bit.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_KEY   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_PTR_L = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_LATCH = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 3'd6;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;
endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_unlock_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] KEY_A = 8'h55,
  parameter logic [DW-1:0] KEY_B = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KS_IDLE:  if (key_wr && wdata == KEY_A) state_d = KS_HALF;
      KS_HALF:  if (acc) state_d = (key_wr && wdata == KEY_B) ? KS_ARMED : KS_IDLE;
      KS_ARMED: if (acc) state_d = KS_IDLE;
      default:  state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_IDLE;
    else     state_q <= state_d;
  end

  assign armed = (state_q == KS_ARMED);

  // R4: the armed window lasts for one bus access only
  a_r4_one_access: assert property (@(posedge clk) disable iff (rst)
    armed && acc |=> !armed);
  // R4: arming needs a key write in the cycle before
  a_r4_arm_by_key: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_wr));
endmodule

// File: rtl/nvm_ptr_regs.sv
module nvm_ptr_regs #(
  parameter int unsigned PTR_W = 22,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 3,
  parameter logic [AW-1:0] BASE = 3'd2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    rd_byte
);
  localparam int unsigned NB = (PTR_W + DW - 1) / DW;

  logic [DW-1:0] rb [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int unsigned LO = g * DW;
    localparam int unsigned BW = (PTR_W - LO < DW) ? (PTR_W - LO) : DW;
    logic [BW-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && addr == AW'(int'(BASE) + g)) q <= wdata[BW-1:0];
    end

    assign ptr[LO +: BW] = q;
    assign rb[g] = DW'(q);
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NB; i++)
      if (addr == AW'(int'(BASE) + i)) rd_byte = rb[i];
  end
endmodule

// File: rtl/nvm_ctrl_core.sv
module nvm_ctrl_core (
  input  logic       clk,
  input  logic       rst_por,
  input  logic       rst_warm,
  input  logic       ctrl_wr,
  input  logic       w_prog,
  input  logic       w_cfg,
  input  logic       w_err,
  input  logic       w_wen,
  input  logic       w_go,
  input  logic       flag_wr,
  input  logic       flag_bit,
  input  logic       armed,
  input  logic       mem_done,
  output logic [7:0] ctrl_q,
  output logic       go,
  output logic       start_pulse,
  output logic       irq,
  output logic       prog,
  output logic       cfg
);
  logic wen, werr;

  always_ff @(posedge clk) begin
    if (rst_por) begin
      go <= 1'b0; start_pulse <= 1'b0; irq <= 1'b0;
      wen <= 1'b0; werr <= 1'b0; prog <= 1'b0; cfg <= 1'b0;
    end else if (rst_warm) begin
      werr <= werr | go;
      go <= 1'b0; start_pulse <= 1'b0; irq <= 1'b0;
      wen <= 1'b0; prog <= 1'b0; cfg <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (ctrl_wr) begin
        wen <= w_wen;
        if (!go) begin
          prog <= w_prog;
          cfg  <= w_cfg;
        end
        if (!w_err) werr <= 1'b0;
        if (w_go && armed && wen && !go) begin
          go <= 1'b1;
          start_pulse <= 1'b1;
        end
      end
      if (go && mem_done) go <= 1'b0;
      if (flag_wr && !flag_bit) irq <= 1'b0;
      if (go && mem_done) irq <= 1'b1;
    end
  end

  assign ctrl_q = {prog, cfg, 2'b00, werr, wen, go, 1'b0};

  // R6: a running write holds until the memory reports done
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    go && !mem_done |=> go);
  // R6: completion ends the write and raises the flag
  a_r6_done_ends: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    go && mem_done |=> !go && irq);
  // R3: the strobe marks the first cycle of a write
  a_r3_strobe_first: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    start_pulse |-> go && !$past(go));
  // R8: the flag only drops by a software clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    irq && !(flag_wr && !flag_bit) |=> irq);
  // R9: a warm reset during a write leaves the error bit set
  a_r9_err_kept: assert property (@(posedge clk) disable iff (rst_por)
    rst_warm && go |=> ctrl_q[3]);
endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int unsigned PTR_W = 22,
  parameter int unsigned DW    = 8,
  parameter logic [DW-1:0] KEY_A = 8'h55,
  parameter logic [DW-1:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_rst,
  input  logic              wdt_rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              mem_start,
  output logic              cpu_stall,
  input  logic              mem_done,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              mem_prog,
  output logic              mem_cfg,
  output logic              irq_flag
);
  logic rst_warm, rst_any, acc, key_wr, ctrl_wr, flag_wr, armed;
  logic go, prog, cfg;
  logic [7:0] ctrl_q;
  logic [DW-1:0] ptr_rd, latch_q, rd_mux;

  assign rst_warm = mclr_rst | wdt_rst;
  assign rst_any  = rst | rst_warm;
  assign acc      = bus_we | bus_re;
  assign key_wr   = bus_we && bus_addr == ADDR_KEY;
  assign ctrl_wr  = bus_we && bus_addr == ADDR_CTRL;
  assign flag_wr  = bus_we && bus_addr == ADDR_FLAG;

  nvm_key_seq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
    .clk(clk), .rst(rst_any), .acc(acc), .key_wr(key_wr),
    .wdata(bus_wdata), .armed(armed)
  );

  nvm_ptr_regs #(.PTR_W(PTR_W), .DW(DW), .AW(REG_AW), .BASE(ADDR_PTR_L)) u_ptr (
    .clk(clk), .rst(rst_any), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .ptr(mem_addr), .rd_byte(ptr_rd)
  );

  nvm_ctrl_core u_core (
    .clk(clk), .rst_por(rst), .rst_warm(rst_warm), .ctrl_wr(ctrl_wr),
    .w_prog(bus_wdata[7]), .w_cfg(bus_wdata[6]), .w_err(bus_wdata[3]),
    .w_wen(bus_wdata[2]), .w_go(bus_wdata[1]),
    .flag_wr(flag_wr), .flag_bit(bus_wdata[0]), .armed(armed),
    .mem_done(mem_done), .ctrl_q(ctrl_q), .go(go), .start_pulse(mem_start),
    .irq(irq_flag), .prog(prog), .cfg(cfg)
  );

  always_ff @(posedge clk) begin
    if (rst_any) latch_q <= '0;
    else if (bus_we && bus_addr == ADDR_LATCH) latch_q <= bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:  rd_mux = DW'(ctrl_q);
      ADDR_KEY:   rd_mux = '0;
      ADDR_LATCH: rd_mux = latch_q;
      ADDR_FLAG:  rd_mux = DW'(irq_flag);
      default:    rd_mux = ptr_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign cpu_stall = go;
  assign mem_data  = latch_q;
  assign mem_prog  = prog;
  assign mem_cfg   = cfg | mem_addr[PTR_W-1];

  // R2: the key address always reads zero
  a_r2_key_zero: assert property (@(posedge clk) disable iff (rst_any)
    bus_re && bus_addr == ADDR_KEY |=> bus_rdata == '0);
  // R10: the pointer only moves on a bus write
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (rst_any)
    !bus_we |=> $stable(mem_addr));
  // R3: no strobe without a control write in the cycle before
  a_r3_strobe_cause: assert property (@(posedge clk) disable iff (rst_any)
    mem_start |-> $past(ctrl_wr && armed));
endmodule

// File: tb/test_nvm_unlock_ctrl.sv
`timescale 1ns/1ps
module test_nvm_unlock_ctrl;
  logic clk = 1'b0, rst = 1'b1, mclr_rst = 1'b0, wdt_rst = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0, mem_done = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, mem_data;
  logic [21:0] mem_addr;
  logic mem_start, cpu_stall, mem_prog, mem_cfg, irq_flag;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;

  always #2 clk = ~clk;

  nvm_unlock_ctrl i_nvm_unlock_ctrl (
    .clk(clk), .rst(rst), .mclr_rst(mclr_rst), .wdt_rst(wdt_rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_start(mem_start), .cpu_stall(cpu_stall),
    .mem_done(mem_done), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_prog(mem_prog), .mem_cfg(mem_cfg), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data one cycle after each read
  always @(posedge clk) rd_pend <= bus_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("read with no expectation", 1, 0);
      else chk(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock_go(input logic [7:0] ctrl);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, ctrl);
  endtask

  task automatic pulse_reset(input int which);
    if (which == 0) rst = 1'b1; else if (which == 1) mclr_rst = 1'b1; else wdt_rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; mclr_rst = 1'b0; wdt_rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 stall", cpu_stall, 0); chk("R1 strobe", mem_start, 0); chk("R1 irq", irq_flag, 0);
    rd(3'd0, 8'h00, "R1 ctrl"); rd(3'd4, 8'h00, "R1 ptr upper");
    rd(3'd5, 8'h00, "R1 latch"); rd(3'd6, 8'h00, "R1 flag");
    // R2 key address stores nothing
    wr(3'd1, 8'h5A); rd(3'd1, 8'h00, "R2 key reads zero"); rd(3'd0, 8'h00, "R2 ctrl untouched");
    // R10 pointer
    wr(3'd4, 8'hFF); wr(3'd3, 8'h12); wr(3'd2, 8'h34);
    rd(3'd4, 8'h3F, "R10 upper bits masked");
    chk("R10 mem_addr", int'(mem_addr), 'h3F1234); chk("R10 cfg via bit21", mem_cfg, 1);
    wr(3'd4, 8'h05); chk("R10 cfg off", mem_cfg, 0); chk("R10 addr", int'(mem_addr), 'h051234);
    // R11 control layout
    wr(3'd0, 8'hFF); rd(3'd0, 8'hC4, "R11 ctrl unused bits zero");
    chk("R11 mem_prog", mem_prog, 1); chk("R10 cfg via ctrl", mem_cfg, 1);
    wr(3'd5, 8'hA5); chk("R11 mem_data", int'(mem_data), 'hA5);
    wr(3'd0, 8'h04);
    // R4 interleaved read, wrong key, interleaved write
    wr(3'd1, 8'h55); rd(3'd2, 8'h34, "R4 ptr read"); wr(3'd1, 8'hAA); wr(3'd0, 8'h06);
    chk("R4 interleaved read strobe", mem_start, 0); rd(3'd0, 8'h04, "R4 interleaved read");
    wr(3'd1, 8'h55); wr(3'd1, 8'h56); wr(3'd1, 8'hAA); wr(3'd0, 8'h06);
    rd(3'd0, 8'h04, "R4 wrong key");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd5, 8'hA5); wr(3'd0, 8'h06);
    rd(3'd0, 8'h04, "R4 write between"); chk("R4 stall", cpu_stall, 0);
    // R5 no start without prior enable
    wr(3'd0, 8'h00); unlock_go(8'h06);
    chk("R5 strobe", mem_start, 0); rd(3'd0, 8'h04, "R5 ctrl");
    // R3 good start
    unlock_go(8'h86);
    chk("R3 strobe", mem_start, 1); chk("R3 stall", cpu_stall, 1);
    idle(1); chk("R3 strobe one cycle", mem_start, 0);
    // R7 clear attempt ignored
    wr(3'd0, 8'h84); chk("R7 stall kept", cpu_stall, 1); rd(3'd0, 8'h86, "R7 ctrl");
    idle(3); chk("R6 stall held", cpu_stall, 1);
    // R6 completion
    mem_done = 1'b1; @(negedge clk); mem_done = 1'b0;
    chk("R6 stall clear", cpu_stall, 0); chk("R6 irq", irq_flag, 1);
    rd(3'd0, 8'h84, "R6 ctrl"); rd(3'd6, 8'h01, "R6 flag");
    // R8 sticky flag
    wr(3'd6, 8'h01); rd(3'd6, 8'h01, "R8 write one no effect");
    wr(3'd6, 8'h00); rd(3'd6, 8'h00, "R8 cleared");
    // R8 completion and clear in the same cycle
    unlock_go(8'h86); chk("R8 started", cpu_stall, 1);
    mem_done = 1'b1; bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h00;
    @(negedge clk); mem_done = 1'b0; bus_we = 1'b0;
    chk("R8 same cycle irq", irq_flag, 1); rd(3'd6, 8'h01, "R8 same cycle flag");
    // R9 master clear during write
    wr(3'd6, 8'h00);
    unlock_go(8'h86); chk("R9 started", cpu_stall, 1);
    pulse_reset(1);
    chk("R9 stall after mclr", cpu_stall, 0);
    rd(3'd0, 8'h08, "R9 error after mclr"); rd(3'd2, 8'h00, "R9 ptr cleared");
    wr(3'd0, 8'h00); rd(3'd0, 8'h00, "R9 software clear");
    pulse_reset(1); rd(3'd0, 8'h00, "R9 idle mclr no error");
    // R9 watchdog then power-on
    wr(3'd0, 8'h04); unlock_go(8'h06); chk("R9 started wdt", cpu_stall, 1);
    pulse_reset(2); rd(3'd0, 8'h08, "R9 error after wdt");
    pulse_reset(0); rd(3'd0, 8'h00, "R9 power-on clears");
    idle(3);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule